// File: doc/BRIEF.md
# Shared Interrupt Spreader

The block takes a set of shared external interrupt inputs and steers each one to the cores of a multi-core cluster. For every core it drives one output per shared input. That core's local interrupt controller numbers those outputs upward from local interrupt 24, so shared input k appears there as interrupt 24 + k. Routing state is held per input: a core mask, a distribution mode, a trigger type and a block bit. This state is loaded through a small command port that carries an opcode, a line number and a data word.

In destination mode an input is sent to every core in its mask. In round-robin mode each new occurrence goes to a single core. That core is the next one in the mask, starting from a per-line pointer. After the occurrence the pointer moves past the chosen core and wraps around the core count.

A level-triggered input is forwarded for as long as it stays high. An edge-triggered input produces a one-cycle pulse on each rising edge. Nothing is forwarded until the unit has been globally enabled.

Top module: `irq_spreader`

## Requirements
- R1: Reset drives every output low, blocks every line, clears every core mask to zero, selects round-robin mode with level trigger, and turns the global enable off.
- R2: Opcode 4 sets the global enable to cmd_data[0]; while it is off, no output is ever raised.
- R3: Opcode 1 loads cmd_data[NUM_CORE-1:0] as the core mask of line cmd_line, with bit c standing for core c; a core outside the mask never receives that line.
- R4: Opcode 2 sets the mode of line cmd_line. cmd_data[1:0] equal to 0 selects round-robin and any other value selects destination mode. cmd_data[4] equal to 1 selects level trigger and 0 selects edge trigger. All other data bits are ignored.
- R5: Opcode 3 blocks line cmd_line when cmd_data[0] is 1 and unblocks it when cmd_data[0] is 0, ignoring the other bits; a blocked line raises no output.
- R6: Line k for core c is driven on core_irq[c*NUM_SRC+k]. Each output is registered, so it reflects the inputs and the routing state of the previous clock cycle.
- R7: A level-triggered line in destination mode drives every core in its mask for as long as the input is high, the line is unblocked and the unit is enabled.
- R8: An edge-triggered line in destination mode gives a one-cycle pulse to every core in its mask for each rising edge of its forwarded request.
- R9: A level-triggered line in round-robin mode drives exactly one core: the first set mask bit at or after the pointer, wrapping around. It holds that core until the request drops; the pointer then moves to the core after it, wrapping to 0.
- R10: An edge-triggered line in round-robin mode sends each rising edge as a one-cycle pulse to one core, chosen as in R9, and the pointer moves past that core on the same edge.
- R11: A line whose core mask is zero reaches no core in either mode.
- R12: Opcodes 0, 5, 6 and 7 change no state, as does any command whose line number is not below NUM_SRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 1 core mask, 2 mode, 3 block, 4 global enable |
| cmd_line | input | $clog2(NUM_SRC) | Shared line addressed by the command |
| cmd_data | input | DATA_W | Command data word |
| src_irq | input | NUM_SRC | Shared interrupt inputs |
| core_irq | output | NUM_CORE*NUM_SRC | Per-core outputs, core c line k at bit c*NUM_SRC+k |

## Verification
A command that rewrites a line's mask, mode, block bit or the global enable can arrive in the same cycle as an occurrence on that line, or as a level request falling and so advancing the round-robin pointer. The bench provokes this with random commands issued in the same cycles as random input toggles. It then judges every output bit of every cycle against a reference model. In that model, an occurrence in a given cycle sees the routing state as it stood before that cycle's command, and the command takes effect only from the next cycle.

// File: rtl/irq_spreader.sv
`timescale 1ns/1ps
module irq_spreader #(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32,
  localparam int LW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int PW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_op,
  input  logic [LW-1:0]                cmd_line,
  input  logic [DATA_W-1:0]            cmd_data,
  input  logic [NUM_SRC-1:0]           src_irq,
  output logic [NUM_CORE*NUM_SRC-1:0]  core_irq
);
  localparam logic [2:0] OP_DEST = 3'd1;
  localparam logic [2:0] OP_MODE = 3'd2;
  localparam logic [2:0] OP_MASK = 3'd3;
  localparam logic [2:0] OP_EN   = 3'd4;

  logic                en;
  logic [NUM_SRC-1:0]  blk, rr, lvl;
  logic [NUM_CORE-1:0] dest [NUM_SRC];
  logic [NUM_SRC*NUM_CORE-1:0] dest_flat;
  logic                hit;
  logic                unused_data;

  assign hit = int'(cmd_line) < NUM_SRC;
  assign unused_data = ^cmd_data;

  function automatic logic [NUM_CORE-1:0] pick(input logic [NUM_CORE-1:0] m,
                                               input logic [PW-1:0] p);
    logic [NUM_CORE-1:0] r;
    r = '0;
    for (int i = NUM_CORE - 1; i >= 0; i--)
      if (m[(int'(p) + i) % NUM_CORE]) r = NUM_CORE'(1) << ((int'(p) + i) % NUM_CORE);
    return r;
  endfunction

  function automatic logic [PW-1:0] after(input logic [NUM_CORE-1:0] oh);
    logic [PW-1:0] r;
    r = '0;
    for (int c = 0; c < NUM_CORE; c++)
      if (oh[c]) r = (c == NUM_CORE - 1) ? '0 : PW'(c + 1);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      blk <= '1;
      rr  <= '1;
      lvl <= '1;
      for (int k = 0; k < NUM_SRC; k++) dest[k] <= '0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_DEST: if (hit) dest[cmd_line] <= cmd_data[NUM_CORE-1:0];
        OP_MODE: if (hit) begin
          rr[cmd_line]  <= (cmd_data[1:0] == 2'b00);
          lvl[cmd_line] <= cmd_data[4];
        end
        OP_MASK: if (hit) blk[cmd_line] <= cmd_data[0];
        OP_EN:   en <= cmd_data[0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_line
    logic                req, req_q, fire, adv;
    logic [PW-1:0]       ptr;
    logic [NUM_CORE-1:0] sel, col_q;

    assign dest_flat[k*NUM_CORE +: NUM_CORE] = dest[k];
    assign req  = en & ~blk[k] & src_irq[k];
    assign sel  = rr[k] ? pick(dest[k], ptr) : dest[k];
    assign fire = lvl[k] ? req : (req & ~req_q);
    assign adv  = rr[k] & (|sel) & (lvl[k] ? (~req & req_q) : fire);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q <= 1'b0;
        ptr   <= '0;
        col_q <= '0;
      end else begin
        req_q <= req;
        col_q <= fire ? sel : '0;
        if (adv) ptr <= after(sel);
      end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      assign core_irq[c*NUM_SRC + k] = col_q[c];
    end
  end
endmodule

// File: rtl/irq_spreader_chk.sv
`timescale 1ns/1ps
module irq_spreader_chk #(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CORE = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         en,
  input logic [NUM_SRC-1:0]           blk,
  input logic [NUM_SRC-1:0]           rr,
  input logic [NUM_SRC*NUM_CORE-1:0]  dest_flat,
  input logic [NUM_CORE*NUM_SRC-1:0]  core_irq
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> core_irq == '0);

  p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> core_irq == '0);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_k
    logic [NUM_CORE-1:0] col;
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_c
      assign col[c] = core_irq[c*NUM_SRC + k];
      p_outside_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dest_flat[k*NUM_CORE + c] |=> !core_irq[c*NUM_SRC + k]);
    end
    p_blocked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      blk[k] |=> col == '0);
    p_rr_one_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rr[k] |=> $onehot0(col));
  end
endmodule

bind irq_spreader irq_spreader_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_chk (.*);

// File: tb/tb_irq_spreader.sv
`timescale 1ns/1ps
module tb_irq_spreader;
  localparam int NS = 8;
  localparam int NC = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_line = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [NS-1:0] src_irq = '0;
  logic [NC*NS-1:0] core_irq;

  irq_spreader #(.NUM_SRC(NS), .NUM_CORE(NC), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_line(cmd_line), .cmd_data(cmd_data), .src_irq(src_irq), .core_irq(core_irq));

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string tag = "R1";

  bit m_en, m_blk[NS], m_rr[NS], m_lvl[NS], m_rq[NS];
  logic [NC-1:0] m_dest[NS];
  int m_ptr[NS];
  logic [NC*NS-1:0] m_exp;

  function automatic logic [NC-1:0] first_from(logic [NC-1:0] m, int p);
    for (int i = 0; i < NC; i++)
      if (m[(p + i) % NC]) return NC'(1) << ((p + i) % NC);
    return '0;
  endfunction

  function automatic int idx_of(logic [NC-1:0] oh);
    for (int c = 0; c < NC; c++) if (oh[c]) return c;
    return 0;
  endfunction

  task automatic model_step();
    m_exp = '0;
    if (!rst_n) begin
      m_en = 0;
      for (int k = 0; k < NS; k++) begin
        m_blk[k] = 1; m_rr[k] = 1; m_lvl[k] = 1; m_rq[k] = 0;
        m_dest[k] = '0; m_ptr[k] = 0;
      end
      return;
    end
    for (int k = 0; k < NS; k++) begin
      bit req, fire, adv;
      logic [NC-1:0] sel;
      req  = m_en && !m_blk[k] && src_irq[k];
      sel  = m_rr[k] ? first_from(m_dest[k], m_ptr[k]) : m_dest[k];
      fire = m_lvl[k] ? req : (req && !m_rq[k]);
      for (int c = 0; c < NC; c++) m_exp[c*NS + k] = fire & sel[c];
      adv = m_rr[k] && (sel != 0) && (m_lvl[k] ? (!req && m_rq[k]) : fire);
      if (adv) m_ptr[k] = (idx_of(sel) + 1) % NC;
      m_rq[k] = req;
    end
    if (cmd_valid) begin
      case (cmd_op)
        3'd1: m_dest[cmd_line] = cmd_data[NC-1:0];
        3'd2: begin m_rr[cmd_line] = (cmd_data[1:0] == 0); m_lvl[cmd_line] = cmd_data[4]; end
        3'd3: m_blk[cmd_line] = cmd_data[0];
        3'd4: m_en = cmd_data[0];
        default: ;
      endcase
    end
  endtask

  task automatic chk(string t, logic [NC*NS-1:0] act, logic [NC*NS-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: core_irq actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk(tag, core_irq, m_exp);
  endtask

  task automatic cmd(logic [2:0] op, int line, logic [DW-1:0] data);
    cmd_valid = 1; cmd_op = op; cmd_line = 3'(line); cmd_data = data;
    tick();
    cmd_valid = 0;
  endtask

  function automatic logic [NC*NS-1:0] bit_at(int c, int k);
    return (NC*NS)'(1) << (c*NS + k);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tag = "R1";
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 reset outputs", core_irq, '0);
    cmd(3'd4, 0, 32'd1);
    src_irq = '1; tick(); tick();
    chk("R1 lines blocked after reset", core_irq, '0);
    src_irq = '0; tick();

    tag = "R2";
    cmd(3'd4, 0, 32'd0);
    cmd(3'd1, 0, 32'h1);
    cmd(3'd2, 0, 32'h11);
    cmd(3'd3, 0, 32'h0);
    src_irq[0] = 1; tick(); tick();
    chk("R2 disabled", core_irq, '0);
    cmd(3'd4, 0, 32'd1);
    tick();
    chk("R2 enabled", core_irq, bit_at(0, 0));
    src_irq[0] = 0; tick();

    tag = "R7";
    cmd(3'd1, 3, 32'hA);
    cmd(3'd2, 3, 32'h12);
    cmd(3'd3, 3, 32'h0);
    src_irq[3] = 1; tick(); tick();
    chk("R3 R6 R7 level destination", core_irq, bit_at(1, 3) | bit_at(3, 3));

    tag = "R12";
    cmd(3'd0, 3, '1); cmd(3'd5, 3, '1); cmd(3'd6, 3, '1); cmd(3'd7, 3, '1);
    tick();
    chk("R12 unused opcodes", core_irq, bit_at(1, 3) | bit_at(3, 3));
    src_irq[3] = 0; tick();

    tag = "R8";
    cmd(3'd1, 5, 32'h3);
    cmd(3'd2, 5, 32'h01);
    cmd(3'd3, 5, 32'h0);
    src_irq[5] = 1; tick();
    chk("R8 edge pulse", core_irq, bit_at(0, 5) | bit_at(1, 5));
    tick();
    chk("R8 pulse one cycle", core_irq, '0);
    src_irq[5] = 0; tick();

    tag = "R9";
    cmd(3'd1, 1, 32'h5);
    cmd(3'd2, 1, 32'h10);
    cmd(3'd3, 1, 32'h0);
    for (int n = 0; n < 3; n++) begin
      int core;
      core = (n == 1) ? 2 : 0;
      src_irq[1] = 1; tick();
      chk("R9 rr level pick", core_irq, bit_at(core, 1));
      tick();
      chk("R9 rr level hold", core_irq, bit_at(core, 1));
      src_irq[1] = 0; tick();
    end

    tag = "R10";
    cmd(3'd1, 2, 32'hE);
    cmd(3'd2, 2, 32'h00);
    cmd(3'd3, 2, 32'h0);
    for (int n = 0; n < 4; n++) begin
      int core;
      core = (n == 3) ? 1 : n + 1;
      src_irq[2] = 1; tick();
      chk("R10 rr edge", core_irq, bit_at(core, 2));
      src_irq[2] = 0; tick();
    end

    tag = "R11";
    cmd(3'd2, 6, 32'h10);
    cmd(3'd3, 6, 32'h0);
    src_irq[6] = 1; tick(); tick();
    chk("R11 zero mask", core_irq, '0);
    src_irq[6] = 0; tick();

    tag = "R4";
    cmd(3'd1, 4, 32'h4);
    cmd(3'd2, 4, 32'hFFFF_FFEC);
    cmd(3'd3, 4, 32'hFFFF_FFFE);
    src_irq[4] = 1; tick();
    chk("R4 R5 ignored data bits", core_irq, bit_at(2, 4));
    tick();
    chk("R4 edge after ignored bits", core_irq, '0);
    cmd(3'd3, 4, 32'h1);
    src_irq[4] = 0; tick();
    src_irq[4] = 1; tick();
    chk("R5 blocked line", core_irq, '0);
    src_irq = '0; tick();

    tag = "R6";
    for (int n = 0; n < 5000; n++) begin
      for (int k = 0; k < NS; k++)
        if ($urandom_range(3) == 0) src_irq[k] = ~src_irq[k];
      if ($urandom_range(9) < 3) begin
        cmd_valid = 1;
        cmd_op = 3'($urandom_range(7));
        cmd_line = 3'($urandom_range(NS - 1));
        cmd_data = $urandom();
        if (cmd_op == 3'd4 || cmd_op == 3'd3) cmd_data[0] = ($urandom_range(5) != 0) ^ (cmd_op == 3'd3);
      end else begin
        cmd_valid = 0;
      end
      tick();
    end
    cmd_valid = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule